// File: doc/BRIEF.md
# Asynchronous Byte-Lane Static Memory Controller

This block lets an on-chip client perform single-word reads and writes on an external asynchronous 1M x 16 nonvolatile static memory. The client side is a valid/ready request channel carrying a write flag, a 20-bit word address, 16 bits of write data and two byte-enable bits. Read results come back on a one-cycle response strobe with the 16-bit data. There is no back-pressure on the response: the client must take `rsp_valid` whenever it is asserted. The request channel has the usual rules. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high. All request fields are sampled only on that edge. `req_ready` depends on the controller state only, never on `req_valid`.

On the memory side the controller drives active-low chip select, write strobe, output strobe and lower/upper lane selects. It also drives the word address and a split tristate data bus: an output word, an output-enable and an input word. Every analog timing interval is a parameter in picoseconds. The controller turns each one into whole clock cycles using the clock-period parameter. A down-counter then holds each phase of the access for its computed length. As a result, setup, strobe width, recovery and bus-release turnaround are enforced separately rather than as one lumped wait state.

Top module: `asram_lane_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `mem_ce_n`, `mem_we_n`, `mem_oe_n`, `mem_lb_n` and `mem_ub_n` are all 1. In the same cycles `mem_dq_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: The write phases run in a fixed order.
  - First, `mem_ce_n` is 0 and `mem_we_n` is 1 for SETUP cycles.
  - Next, `mem_we_n` is 0 for PULSE cycles. PULSE is the largest of three cycle counts: the write strobe width, the address-valid-to-write-end time and the data-setup-to-write-end time.
  - `mem_dq_oe` is 1, with `mem_dq_out` equal to the request data, in exactly the cycles where `mem_we_n` is 0.
- R3: After the write strobe rises, all memory strobes stay 1 for RECOVER cycles. `req_ready` then returns to 1. A write with at least one lane enabled therefore keeps `req_ready` low for SETUP+PULSE+RECOVER cycles.
- R4: A read holds `mem_ce_n` and `mem_oe_n` at 0, with `mem_we_n` at 1, for READ cycles. The data is sampled on the last of these cycles. `rsp_valid` is 1 for the following cycle.
- R5: After a read, all memory strobes are 1 for TURN cycles. TURN is the cycle count of the largest bus-release time among output-strobe, lane-select and chip-select release. `req_ready` stays low during these cycles, so a read keeps it low for READ+TURN cycles.
- R6: Each byte-enable bit controls one byte lane of the data bus.
  - `req_be[0]` controls bits 7:0 and `mem_lb_n`. `req_be[1]` controls bits 15:8 and `mem_ub_n`.
  - A lane select is 0 throughout an access whose matching enable bit is 1, and 1 throughout otherwise.
  - A lane that is not enabled keeps its stored byte across a write.
- R7: In a read response, the byte of each lane whose enable bit was 0 is returned as 0x00.
- R8: A request with `req_be` equal to 0 never brings any memory strobe low, and `req_ready` stays 1. If such a request is a read, `rsp_valid` is 1 on the next cycle with `rsp_data` equal to 0.
- R9: `mem_dq_oe` is never 1 while `mem_oe_n` is 0 or `mem_we_n` is 1.
- R10: `mem_addr` equals the accepted request address and does not change while `mem_ce_n` is 0. The lane selects also do not change during an access.
- R11: Each interval converts to cycles as ceil(picoseconds / `CLK_PERIOD_PS`), with a minimum of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle read result strobe |
| rsp_data | output | 16 | Read result, unrequested lanes zero |
| mem_addr | output | 20 | Memory word address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_lb_n | output | 1 | Lower lane select, active low |
| mem_ub_n | output | 1 | Upper lane select, active low |
| mem_dq_out | output | 16 | Data driven toward memory |
| mem_dq_oe | output | 1 | Data bus drive enable toward memory |
| mem_dq_in | input | 16 | Data bus as seen from memory |

## Verification
The assertions assume two things. First, the client changes request fields only while a request is not being accepted. Second, the memory places valid data on `mem_dq_in` before the last read cycle. The controller itself never inspects the bus except on that cycle. The bench satisfies both assumptions in three ways:
- it drives requests only on falling edges and holds `req_valid` until acceptance;
- its memory model answers combinationally from the strobes;
- it puts filler bytes on lanes that are not selected, so any missing masking shows up in the result.

The sweep covers every byte-enable value on writes and on reads at both the lowest and highest addresses. It also runs the controller with stretched read, pulse and chip-release times, so every phase counter is longer than one cycle.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_RD_WAIT    = 3'd1,
    ST_RD_TURN    = 3'd2,
    ST_WR_SETUP   = 3'd3,
    ST_WR_PULSE   = 3'd4,
    ST_WR_RECOVER = 3'd5
  } phase_e;

  // ceil(ps / period), never below one cycle (R11)
  function automatic int unsigned ps_to_cycles(input int unsigned ps, input int unsigned period);
    int unsigned c;
    c = (ps + period - 1) / period;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b, input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
  parameter int unsigned MAX_CYCLES = 4,
  localparam int unsigned CW = $clog2(MAX_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] length,
  output logic          last
);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (load) begin
      remain <= length - CW'(1);
    end else if (remain != '0) begin
      remain <= remain - CW'(1);
    end
  end

  assign last = (remain == '0);

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    remain < CW'(MAX_CYCLES)) else $error("phase timer out of range"); // R11

  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (length != '0)) else $error("zero-length phase"); // R11

endmodule

// File: rtl/asram_lane_gate.sv
module asram_lane_gate #(
  parameter int unsigned DW    = 16,
  parameter int unsigned LANES = 2,
  localparam int unsigned LW   = DW / LANES
) (
  input  logic             active,
  input  logic [LANES-1:0] be,
  input  logic [DW-1:0]    bus_in,
  output logic [DW-1:0]    masked,
  output logic [LANES-1:0] sel_n
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign sel_n[g]                = ~(active & be[g]);
    assign masked[g*LW +: LW]      = be[g] ? bus_in[g*LW +: LW] : '0;
  end

endmodule

// File: rtl/asram_lane_ctrl.sv
module asram_lane_ctrl #(
  parameter int unsigned AW               = 20,
  parameter int unsigned DW               = 16,
  parameter int unsigned LANES            = 2,
  parameter int unsigned CLK_PERIOD_PS    = 20000,
  parameter int unsigned T_RD_ACCESS_PS   = 35000,
  parameter int unsigned T_WR_PULSE_PS    = 15000,
  parameter int unsigned T_ADDR_WEND_PS   = 20000,
  parameter int unsigned T_DATA_SETUP_PS  = 10000,
  parameter int unsigned T_WR_RECOVER_PS  = 12000,
  parameter int unsigned T_ADDR_SETUP_PS  = 0,
  parameter int unsigned T_OE_HIZ_PS      = 10000,
  parameter int unsigned T_LANE_HIZ_PS    = 10000,
  parameter int unsigned T_CE_HIZ_PS      = 15000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [LANES-1:0] req_be,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_data,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_ce_n,
  output logic             mem_we_n,
  output logic             mem_oe_n,
  output logic             mem_lb_n,
  output logic             mem_ub_n,
  output logic [DW-1:0]    mem_dq_out,
  output logic             mem_dq_oe,
  input  logic [DW-1:0]    mem_dq_in
);
  import asram_pkg::*;

  localparam int unsigned SETUP_C = ps_to_cycles(T_ADDR_SETUP_PS, CLK_PERIOD_PS);
  localparam int unsigned PULSE_C = max3(ps_to_cycles(T_WR_PULSE_PS, CLK_PERIOD_PS),
                                         ps_to_cycles(T_ADDR_WEND_PS, CLK_PERIOD_PS),
                                         ps_to_cycles(T_DATA_SETUP_PS, CLK_PERIOD_PS));
  localparam int unsigned RECOV_C = ps_to_cycles(T_WR_RECOVER_PS, CLK_PERIOD_PS);
  localparam int unsigned READ_C  = ps_to_cycles(T_RD_ACCESS_PS, CLK_PERIOD_PS);
  localparam int unsigned TURN_C  = ps_to_cycles(max3(T_OE_HIZ_PS, T_LANE_HIZ_PS, T_CE_HIZ_PS),
                                                 CLK_PERIOD_PS);
  localparam int unsigned MAX_C   = max3(max3(SETUP_C, PULSE_C, RECOV_C), READ_C, TURN_C);
  localparam int unsigned CW      = $clog2(MAX_C + 1);

  phase_e state, nxt;

  logic             tload;
  logic [CW-1:0]    tlen;
  logic             tlast;

  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic [LANES-1:0] be_q;
  logic             accept;
  logic             no_lane;

  logic             nxt_cs, nxt_we, nxt_oe;
  logic [LANES-1:0] be_src;
  logic [LANES-1:0] sel_n;
  logic [DW-1:0]    rd_masked;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid & req_ready;
  assign no_lane   = (req_be == '0);

  // ---------------- phase sequencing ----------------
  always_comb begin
    nxt   = state;
    tload = 1'b0;
    tlen  = CW'(1);
    case (state)
      ST_IDLE: begin
        if (accept && !no_lane) begin
          tload = 1'b1;
          if (req_write) begin
            nxt  = ST_WR_SETUP;
            tlen = CW'(SETUP_C);
          end else begin
            nxt  = ST_RD_WAIT;
            tlen = CW'(READ_C);
          end
        end
      end
      ST_WR_SETUP: if (tlast) begin
        nxt = ST_WR_PULSE;   tload = 1'b1; tlen = CW'(PULSE_C);
      end
      ST_WR_PULSE: if (tlast) begin
        nxt = ST_WR_RECOVER; tload = 1'b1; tlen = CW'(RECOV_C);
      end
      ST_WR_RECOVER: if (tlast) nxt = ST_IDLE;
      ST_RD_WAIT: if (tlast) begin
        nxt = ST_RD_TURN;    tload = 1'b1; tlen = CW'(TURN_C);
      end
      ST_RD_TURN: if (tlast) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  asram_phase_timer #(.MAX_CYCLES(MAX_C)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (tload),
    .length (tlen),
    .last   (tlast)
  );

  // ---------------- request capture ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept && !no_lane) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  // ---------------- pin decode (registered from next phase) ----------------
  assign nxt_cs = (nxt == ST_RD_WAIT) || (nxt == ST_WR_SETUP) || (nxt == ST_WR_PULSE);
  assign nxt_we = (nxt == ST_WR_PULSE);
  assign nxt_oe = (nxt == ST_RD_WAIT);
  assign be_src = (state == ST_IDLE) ? req_be : be_q;

  asram_lane_gate #(.DW(DW), .LANES(LANES)) u_lanes (
    .active (nxt_cs),
    .be     (be_src),
    .bus_in (mem_dq_in),
    .masked (rd_masked),
    .sel_n  (sel_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_lb_n  <= 1'b1;
      mem_ub_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      mem_ce_n  <= ~nxt_cs;
      mem_we_n  <= ~nxt_we;
      mem_oe_n  <= ~nxt_oe;
      mem_lb_n  <= sel_n[0];
      mem_ub_n  <= sel_n[LANES-1];
      mem_dq_oe <= nxt_we;
    end
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;

  // ---------------- read response ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (state == ST_RD_WAIT && tlast) begin
        rsp_valid <= 1'b1;
        rsp_data  <= rd_masked;
      end else if (accept && no_lane && !req_write) begin
        rsp_valid <= 1'b1;
        rsp_data  <= '0;
      end
    end
  end

  // ---------------- assertions ----------------
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && !mem_we_n)) else $error("bus contention"); // R9

  AST_WE_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n) else $error("write strobe without chip select"); // R2

  AST_WE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(!mem_ce_n)) else $error("no setup before strobe"); // R2

  AST_RECOVER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_ce_n) else $error("chip select held after write"); // R3

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)) else $error("address moved"); // R10

  AST_LANES_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable({mem_lb_n, mem_ub_n})) else $error("lane moved"); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !$past(req_ready)) |-> (mem_ce_n && mem_we_n && mem_oe_n))
    else $error("strobe active at ready"); // R5

endmodule

// File: tb/sim_asram_lane_ctrl.sv
`timescale 1ns/1ps
module sim_asram_lane_ctrl;

  localparam int CLKP   = 20000;
  localparam int T_RD   = 55000;
  localparam int T_PW   = 45000;
  localparam int T_AW   = 20000;
  localparam int T_DS   = 10000;
  localparam int T_REC  = 12000;
  localparam int T_AS   = 0;
  localparam int T_OEZ  = 10000;
  localparam int T_BEZ  = 10000;
  localparam int T_CEZ  = 25000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_data;
  logic [19:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [15:0] mem_dq_out, mem_dq_in;

  asram_lane_ctrl #(
    .CLK_PERIOD_PS(CLKP), .T_RD_ACCESS_PS(T_RD), .T_WR_PULSE_PS(T_PW),
    .T_ADDR_WEND_PS(T_AW), .T_DATA_SETUP_PS(T_DS), .T_WR_RECOVER_PS(T_REC),
    .T_ADDR_SETUP_PS(T_AS), .T_OE_HIZ_PS(T_OEZ), .T_LANE_HIZ_PS(T_BEZ),
    .T_CE_HIZ_PS(T_CEZ)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int checks = 0;
  int errors = 0;

  function automatic int cyc(input int ps);
    int c;
    c = (ps + CLKP - 1) / CLKP;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  int e_setup, e_pulse, e_rec, e_read, e_turn;

  // pin-level memory model: unselected lanes return filler bytes
  logic [15:0] mdl [64];
  logic [15:0] shadow [64];
  logic        rd_on;
  assign rd_on = !mem_ce_n && !mem_oe_n && mem_we_n;
  assign mem_dq_in = {(rd_on && !mem_ub_n) ? mdl[mem_addr[5:0]][15:8] : 8'hA5,
                      (rd_on && !mem_lb_n) ? mdl[mem_addr[5:0]][7:0]  : 8'h5A};

  logic [19:0] cur_addr = '0;
  logic        acc_on = 1'b0;

  always @(negedge clk) begin
    if (rst_n && !mem_ce_n && !mem_we_n && mem_dq_oe) begin
      if (!mem_lb_n) mdl[mem_addr[5:0]][7:0]  = mem_dq_out[7:0];
      if (!mem_ub_n) mdl[mem_addr[5:0]][15:8] = mem_dq_out[15:8];
    end
    if (rst_n && mem_dq_oe && (!mem_oe_n || mem_we_n)) begin
      errors++;
      $display("FAIL R9 bus driven oe_n=%0b we_n=%0b expected oe_n=1 we_n=0", mem_oe_n, mem_we_n);
    end
    if (rst_n && acc_on && !mem_ce_n && mem_addr != cur_addr) begin
      errors++;
      $display("FAIL R10 mem_addr=%h expected %h", mem_addr, cur_addr);
    end
    if (rst_n && !mem_we_n && mem_dq_out != req_wdata) begin
      errors++;
      $display("FAIL R2 dq_out=%h expected %h", mem_dq_out, req_wdata);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_req(input bit wr, input logic [19:0] a, input logic [15:0] d,
                        input logic [1:0] be);
    int nbusy, nwe, noe, ncs, ndrv, got, lane_bad;
    logic [15:0] rdat, exp;
    nbusy = 0; nwe = 0; noe = 0; ncs = 0; ndrv = 0; got = 0; lane_bad = 0; rdat = '0;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    cur_addr = a; acc_on = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    forever begin
      if (rsp_valid) begin got++; rdat = rsp_data; end
      if (!mem_we_n) nwe++;
      if (!mem_oe_n) noe++;
      if (!mem_ce_n) begin
        ncs++;
        if (mem_lb_n != !be[0] || mem_ub_n != !be[1]) lane_bad++;
      end
      if (mem_dq_oe) ndrv++;
      if (req_ready) break;
      nbusy++;
      @(negedge clk);
    end
    acc_on = 1'b0;
    if (be == 2'b00) begin
      chk(nbusy == 0 && ncs == 0, "R8 no strobes, ready held", ncs, 0);
      if (!wr) chk(got == 1 && rdat == 16'h0, "R8 empty read returns zero", rdat, 0);
    end else if (wr) begin
      chk(nbusy == e_setup + e_pulse + e_rec, "R3 write busy cycles", nbusy, e_setup + e_pulse + e_rec);
      chk(nwe == e_pulse && ndrv == e_pulse, "R2 strobe/drive cycles", nwe, e_pulse);
      chk(ncs == e_setup + e_pulse, "R2 select cycles", ncs, e_setup + e_pulse);
      chk(lane_bad == 0, "R6 lane selects on write", lane_bad, 0);
      if (be[0]) shadow[a[5:0]][7:0]  = d[7:0];
      if (be[1]) shadow[a[5:0]][15:8] = d[15:8];
    end else begin
      exp = {be[1] ? shadow[a[5:0]][15:8] : 8'h00, be[0] ? shadow[a[5:0]][7:0] : 8'h00};
      chk(nbusy == e_read + e_turn, "R5 read busy cycles", nbusy, e_read + e_turn);
      chk(noe == e_read && ncs == e_read, "R4 output strobe cycles", noe, e_read);
      chk(got == 1, "R4 single response pulse", got, 1);
      chk(rdat == exp, "R7 read data with lane masking", rdat, exp);
      chk(lane_bad == 0 && ndrv == 0, "R6 lane selects on read", lane_bad, 0);
    end
  endtask

  initial begin
    e_setup = cyc(T_AS);
    e_pulse = imax(imax(cyc(T_PW), cyc(T_AW)), cyc(T_DS));
    e_rec   = cyc(T_REC);
    e_read  = cyc(T_RD);
    e_turn  = cyc(imax(imax(T_OEZ, T_BEZ), T_CEZ));
    for (int i = 0; i < 64; i++) begin
      mdl[i]    = 16'h3C00 ^ (16'(i) * 16'h0101);
      shadow[i] = 16'h3C00 ^ (16'(i) * 16'h0101);
    end
    repeat (4) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !mem_dq_oe,
        "R1 strobes idle in reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 5'h1f);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_dq_oe && mem_ce_n, "R1 state after reset",
        {req_ready, rsp_valid}, 2'b10);
    // R11: stretched parameters must give multi-cycle phases
    chk(e_read == 3 && e_pulse == 3 && e_turn == 2 && e_setup == 1, "R11 cycle rounding",
        e_read, 3);

    for (int a = 0; a < 8; a++) begin
      logic [19:0] adr;
      adr = (a[0] ? 20'hFFFC0 : 20'h00000) | 20'(a * 5);
      for (int bw = 0; bw < 4; bw++) begin
        do_req(1'b1, adr, 16'((a * 16'h1357) ^ (bw * 16'h2468) ^ 16'h9A00), 2'(bw));
        for (int br = 0; br < 4; br++)
          do_req(1'b0, adr, 16'hFFFF, 2'(br));
      end
    end
    // back-to-back empty-lane requests then a real one
    do_req(1'b0, 20'h00003, 16'h0, 2'b00);
    do_req(1'b1, 20'h00003, 16'hBEEF, 2'b00);
    do_req(1'b0, 20'h00003, 16'h0, 2'b11);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule